// File: doc/BRIEF.md
# SMBus Target Address Strap Latch

This block chooses the 7-bit SMBus target address that a monitoring device responds to. Two pins are shared between strapping and fan duty: an enable strap pin, which later becomes a PWM fan output, and a select strap pin, which later becomes a fan tachometer input. While the choice is still open, the block follows the synchronized pin levels. An enable pin that reads high gives the default address 0x2E. An enable pin that reads low selects between 0x2C (select low) and 0x2D (select high).

The choice becomes permanent only when a whole bus transaction completes after an address phase whose upper five address bits equal 5'b01011. An address event from the slave engine marks that phase, and a stop event marks the end of the transaction. The candidate address present at the matching address phase is held while the transaction runs. When the transaction ends with a stop, that address is locked, the PWM output driver is enabled and the tachometer pin is handed to the fan logic. Any other traffic leaves the choice open, so noise or traffic for other targets cannot fix the address.

The block also watches the clock and data lines for a stuck-low condition. When either line has stayed low for a set number of timer ticks, it sends a single-cycle reset pulse to the slave engine. If that pulse arrives while a matching transaction is still open, the pending choice is dropped. A locked address survives every bus event and is cleared only by the power-on reset.

Top module: `smb_addr_strap`

## Requirements
- R1: After power-on reset the address is unlocked, `addr_locked`, `pwm_drv_en`, `tach_fan_sel` and `bus_reset` are 0, and `dev_addr` shows 0x2E until pin levels have passed through the synchronizer.
- R2: While unlocked and with no pending match, a high enable strap pin gives `dev_addr` = 0x2E, whatever the select pin level.
- R3: While unlocked and with no pending match, a low enable strap pin gives `dev_addr` = 0x2C when the select pin is low and 0x2D when it is high.
- R4: Strap pins pass through SYNC_STAGES (default 2) flip-flops: a pin change made between clock edges shows on `dev_addr` after the second following rising edge, not after the first.
- R5: An `addr_evt` pulse whose `addr_byte[6:2]` equals 5'b01011 captures the candidate address of that cycle. Until the transaction ends or is aborted, `dev_addr` keeps that value regardless of the pins.
- R6: An `addr_evt` pulse whose `addr_byte[6:2]` differs from 5'b01011 has no effect: `dev_addr` keeps following the pins.
- R7: A `stop_evt` while a match is pending sets `addr_locked`, `pwm_drv_en` and `tach_fan_sel` to 1 after that clock edge, with `dev_addr` holding the captured address.
- R8: A `stop_evt` with no pending match does not lock.
- R9: When `scl_in` or `sda_in` has been low for TIMEOUT_TICKS (default 30) cycles with `tick` high, `bus_reset` pulses high for exactly one cycle, in the cycle after the tick that completes the count. The count clears whenever both lines are high, cycles with `tick` low do not advance it, and no further pulse comes until the lines are released.
- R10: A `bus_reset` pulse while a match is pending drops it, and this takes priority over a `stop_evt` in the same cycle. `dev_addr` then follows the pins again.
- R11: Once locked, `dev_addr`, `addr_locked`, `pwm_drv_en` and `tach_fan_sel` do not change for any pin level, address event, stop event or timeout until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| tick | input | 1 | Timebase strobe for the stuck-bus counter |
| scl_in | input | 1 | Sampled SMBus clock line level |
| sda_in | input | 1 | Sampled SMBus data line level |
| strap_en_pin | input | 1 | Level of the enable strap pin (later the PWM output) |
| strap_sel_pin | input | 1 | Level of the select strap pin (later the tachometer input) |
| addr_evt | input | 1 | One-cycle pulse: the slave engine has decoded an address phase |
| addr_byte | input | 7 | 7-bit target address decoded in that phase |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| dev_addr | output | 7 | Address the slave engine must answer to |
| addr_locked | output | 1 | Address is fixed until power-on reset |
| pwm_drv_en | output | 1 | 1 lets the PWM driver use the enable pin; 0 keeps it released |
| tach_fan_sel | output | 1 | 1 routes the select pin to the tachometer logic |
| bus_reset | output | 1 | One-cycle stuck-bus reset pulse to the slave engine |

## Verification
The assertions check the properties that hold on every cycle. A lock never goes away and the locked address never moves. A lock appears only in the cycle after a stop. The address is always one of the three legal values. Every stuck-bus pulse lasts one cycle and follows a low line. The bench scenarios are needed to show which address is captured and when: the two-edge synchronizer delay, the choice made at the matching address phase, non-matching traffic being ignored, and a timeout dropping a pending match but not a locked one.

// File: rtl/smb_strap_pkg.sv
package smb_strap_pkg;

   typedef enum logic [1:0] {
      LK_OPEN = 2'd0,
      LK_PEND = 2'd1,
      LK_HELD = 2'd2
   } lock_state_e;

   typedef struct packed {
      logic en;
      logic sel;
   } strap_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync
   import smb_strap_pkg::*;
#(
   parameter int   STAGES  = 2,
   parameter logic RST_EN  = 1'b1,
   parameter logic RST_SEL = 1'b0
) (
   input  logic   clk,
   input  logic   por_n,
   input  strap_t raw,
   output strap_t synced
);
   localparam strap_t RST_VAL = '{en: RST_EN, sel: RST_SEL};

   generate
      if (STAGES == 0) begin : g_bypass
         assign synced = raw;
      end else begin : g_chain
         strap_t chain_q [STAGES];
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
            end else begin
               chain_q[0] <= raw;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bus_stuck_timer.sv
module bus_stuck_timer #(
   parameter int LIMIT = 30,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick,
   input  logic scl_in,
   input  logic sda_in,
   output logic stuck_pulse
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(LIMIT);

   logic             idle_hi;
   logic [CNT_W-1:0] low_cnt_q;
   logic             pulse_q;

   assign idle_hi = scl_in && sda_in;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         low_cnt_q <= '0;
         pulse_q   <= 1'b0;
      end else begin
         pulse_q <= !idle_hi && tick && (low_cnt_q == LAST);
         if (idle_hi)
            low_cnt_q <= '0;
         else if (tick && (low_cnt_q != FULL))
            low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   assign stuck_pulse = pulse_q;
endmodule

// File: rtl/addr_lock_ctrl.sv
module addr_lock_ctrl
   import smb_strap_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int PREFIX_W = 5,
   parameter logic [PREFIX_W-1:0] PREFIX   = 5'b01011,
   parameter logic [ADDR_W-1:0]   ADDR_DEF = 7'h2E,
   parameter logic [ADDR_W-1:0]   ADDR_S0  = 7'h2C,
   parameter logic [ADDR_W-1:0]   ADDR_S1  = 7'h2D
) (
   input  logic              clk,
   input  logic              por_n,
   input  strap_t            strap,
   input  logic              addr_evt,
   input  logic [ADDR_W-1:0] addr_byte,
   input  logic              stop_evt,
   input  logic              abort,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              locked
);
   localparam int SHIFT = ADDR_W - PREFIX_W;

   lock_state_e       state_q;
   logic [ADDR_W-1:0] held_q;
   logic [ADDR_W-1:0] cand;
   logic              prefix_hit;

   assign cand       = strap.en ? ADDR_DEF : (strap.sel ? ADDR_S1 : ADDR_S0);
   assign prefix_hit = (addr_byte >> SHIFT) == ADDR_W'(PREFIX);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= LK_OPEN;
         held_q  <= ADDR_DEF;
      end else begin
         unique case (state_q)
            LK_OPEN: if (addr_evt && prefix_hit) begin
               state_q <= LK_PEND;
               held_q  <= cand;
            end
            LK_PEND: if (abort)
               state_q <= LK_OPEN;
            else if (stop_evt)
               state_q <= LK_HELD;
            default: state_q <= LK_HELD;
         endcase
      end
   end

   assign dev_addr = (state_q == LK_OPEN) ? cand : held_q;
   assign locked   = (state_q == LK_HELD);
endmodule

// File: rtl/smb_addr_strap.sv
module smb_addr_strap
   import smb_strap_pkg::*;
#(
   parameter int ADDR_W        = 7,
   parameter int PREFIX_W      = 5,
   parameter logic [PREFIX_W-1:0] PREFIX   = 5'b01011,
   parameter logic [ADDR_W-1:0]   ADDR_DEF = 7'h2E,
   parameter logic [ADDR_W-1:0]   ADDR_S0  = 7'h2C,
   parameter logic [ADDR_W-1:0]   ADDR_S1  = 7'h2D,
   parameter int SYNC_STAGES   = 2,
   parameter int TIMEOUT_TICKS = 30
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              tick,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              strap_en_pin,
   input  logic              strap_sel_pin,
   input  logic              addr_evt,
   input  logic [ADDR_W-1:0] addr_byte,
   input  logic              stop_evt,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              addr_locked,
   output logic              pwm_drv_en,
   output logic              tach_fan_sel,
   output logic              bus_reset
);
   localparam int SHIFT = ADDR_W - PREFIX_W;

   generate
      if (PREFIX_W < 1 || PREFIX_W > ADDR_W) begin : g_bad_prefix
         $error("smb_addr_strap: PREFIX_W must be 1..ADDR_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("smb_addr_strap: SYNC_STAGES must be 0..4");
      end
      if (TIMEOUT_TICKS < 1) begin : g_bad_timeout
         $error("smb_addr_strap: TIMEOUT_TICKS must be at least 1");
      end
      if ((ADDR_DEF >> SHIFT) != ADDR_W'(PREFIX) ||
          (ADDR_S0  >> SHIFT) != ADDR_W'(PREFIX) ||
          (ADDR_S1  >> SHIFT) != ADDR_W'(PREFIX)) begin : g_bad_addr
         $error("smb_addr_strap: strap addresses must share the match prefix");
      end
   endgenerate

   strap_t raw_pins;
   strap_t synced_pins;
   logic   stuck;
   logic   locked;

   assign raw_pins = '{en: strap_en_pin, sel: strap_sel_pin};

   strap_sync #(
      .STAGES (SYNC_STAGES),
      .RST_EN (1'b1),
      .RST_SEL(1'b0)
   ) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .raw   (raw_pins),
      .synced(synced_pins)
   );

   bus_stuck_timer #(
      .LIMIT(TIMEOUT_TICKS)
   ) u_timer (
      .clk        (clk),
      .por_n      (por_n),
      .tick       (tick),
      .scl_in     (scl_in),
      .sda_in     (sda_in),
      .stuck_pulse(stuck)
   );

   addr_lock_ctrl #(
      .ADDR_W  (ADDR_W),
      .PREFIX_W(PREFIX_W),
      .PREFIX  (PREFIX),
      .ADDR_DEF(ADDR_DEF),
      .ADDR_S0 (ADDR_S0),
      .ADDR_S1 (ADDR_S1)
   ) u_lock (
      .clk      (clk),
      .por_n    (por_n),
      .strap    (synced_pins),
      .addr_evt (addr_evt),
      .addr_byte(addr_byte),
      .stop_evt (stop_evt),
      .abort    (stuck),
      .dev_addr (dev_addr),
      .locked   (locked)
   );

   assign addr_locked  = locked;
   assign pwm_drv_en   = locked;
   assign tach_fan_sel = locked;
   assign bus_reset    = stuck;
endmodule

// File: rtl/smb_addr_strap_chk.sv
module smb_addr_strap_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              por_n,
   input logic              scl_in,
   input logic              sda_in,
   input logic              stop_evt,
   input logic [ADDR_W-1:0] dev_addr,
   input logic              addr_locked,
   input logic              bus_reset
);
   // R11: a lock never drops and the locked address never moves
   a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
      addr_locked |=> (addr_locked && $stable(dev_addr)));

   // R7 and R8: a lock appears only in the cycle after a stop event
   a_r7_lock_after_stop: assert property (@(posedge clk) disable iff (!por_n)
      $rose(addr_locked) |-> $past(stop_evt));

   // R9: the stuck-bus reset is a single-cycle pulse
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
      bus_reset |=> !bus_reset);

   // R9: a pulse requires a line to have been low at the previous edge
   a_r9_pulse_needs_low: assert property (@(posedge clk) disable iff (!por_n)
      bus_reset |-> $past(!(scl_in && sda_in)));

   // R2 and R3: only the three strap addresses can be presented
   a_r3_addr_legal: assert property (@(posedge clk) disable iff (!por_n)
      (dev_addr == 7'h2C) || (dev_addr == 7'h2D) || (dev_addr == 7'h2E));
endmodule

bind smb_addr_strap smb_addr_strap_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .scl_in     (scl_in),
   .sda_in     (sda_in),
   .stop_evt   (stop_evt),
   .dev_addr   (dev_addr),
   .addr_locked(addr_locked),
   .bus_reset  (bus_reset)
);

// File: tb/smb_addr_strap_tb_top.sv
`timescale 1ns/1ps
module smb_addr_strap_tb_top;
   localparam int LIMIT = 30;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick = 1'b1;
   logic       scl_in = 1'b1;
   logic       sda_in = 1'b1;
   logic       strap_en_pin = 1'b1;
   logic       strap_sel_pin = 1'b0;
   logic       addr_evt = 1'b0;
   logic [6:0] addr_byte = 7'h00;
   logic       stop_evt = 1'b0;
   logic [6:0] dev_addr;
   logic       addr_locked, pwm_drv_en, tach_fan_sel, bus_reset;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   string cur_req  = "R1";

   always #4 clk = ~clk;

   smb_addr_strap dut_i (
      .clk(clk), .por_n(por_n), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
      .strap_en_pin(strap_en_pin), .strap_sel_pin(strap_sel_pin),
      .addr_evt(addr_evt), .addr_byte(addr_byte), .stop_evt(stop_evt),
      .dev_addr(dev_addr), .addr_locked(addr_locked), .pwm_drv_en(pwm_drv_en),
      .tach_fan_sel(tach_fan_sel), .bus_reset(bus_reset)
   );

   // behavioural reference model
   bit       q_en[$];
   bit       q_sel[$];
   int       m_low;
   bit       m_pulse;
   int       m_state;   // 0 open, 1 pending, 2 locked
   bit [6:0] m_held;

   function automatic bit [6:0] strap_addr(bit en, bit sel);
      if (en) return 7'h2E;
      return sel ? 7'h2D : 7'h2C;
   endfunction

   always @(posedge clk or negedge por_n) begin
      bit [6:0] c;
      bit       pulse_now;
      if (!por_n) begin
         q_en = '{1'b1, 1'b1};
         q_sel = '{1'b0, 1'b0};
         m_low = 0; m_pulse = 1'b0; m_state = 0; m_held = 7'h2E;
      end else begin
         c = strap_addr(q_en[0], q_sel[0]);
         pulse_now = m_pulse;
         m_pulse = !(scl_in && sda_in) && tick && (m_low == LIMIT - 1);
         if (scl_in && sda_in) m_low = 0;
         else if (tick && m_low < LIMIT) m_low++;
         if (m_state == 0) begin
            if (addr_evt && addr_byte[6:2] == 5'b01011) begin
               m_state = 1; m_held = c;
            end
         end else if (m_state == 1) begin
            if (pulse_now) m_state = 0;
            else if (stop_evt) m_state = 2;
         end
         q_en.push_back(strap_en_pin);  void'(q_en.pop_front());
         q_sel.push_back(strap_sel_pin); void'(q_sel.pop_front());
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      bit [6:0] e_addr;
      bit       e_lk;
      if (por_n && !done) begin
         e_addr = (m_state == 0) ? strap_addr(q_en[0], q_sel[0]) : m_held;
         e_lk   = (m_state == 2);
         chk(dev_addr == e_addr, cur_req, "model dev_addr", dev_addr, e_addr);
         chk(addr_locked == e_lk && pwm_drv_en == e_lk && tach_fan_sel == e_lk,
             cur_req, "model lock/modes", {addr_locked, pwm_drv_en, tach_fan_sel},
             {e_lk, e_lk, e_lk});
         chk(bus_reset == m_pulse, cur_req, "model bus_reset", bus_reset, m_pulse);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_addr(bit [6:0] a);
      addr_evt = 1'b1; addr_byte = a; cyc(1);
      addr_evt = 1'b0; cyc(1);
   endtask

   task automatic send_stop();
      stop_evt = 1'b1; cyc(1);
      stop_evt = 1'b0; cyc(1);
   endtask

   task automatic do_reset();
      @(negedge clk); por_n = 1'b0; cyc(3); por_n = 1'b1; cyc(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      do_reset();
      cur_req = "R1";
      chk(addr_locked == 0 && pwm_drv_en == 0 && tach_fan_sel == 0, "R1", "reset lock/modes",
          {addr_locked, pwm_drv_en, tach_fan_sel}, 0);
      chk(bus_reset == 0, "R1", "reset bus_reset", bus_reset, 0);
      chk(dev_addr == 7'h2E, "R1", "reset dev_addr", dev_addr, 7'h2E);

      cur_req = "R2";
      strap_sel_pin = 1'b1; cyc(3);
      chk(dev_addr == 7'h2E, "R2", "enable high, select high", dev_addr, 7'h2E);

      cur_req = "R3";
      strap_en_pin = 1'b0; strap_sel_pin = 1'b0; cyc(3);
      chk(dev_addr == 7'h2C, "R3", "select low", dev_addr, 7'h2C);

      cur_req = "R4";
      strap_sel_pin = 1'b1; cyc(1);
      chk(dev_addr == 7'h2C, "R4", "one edge after change", dev_addr, 7'h2C);
      cyc(1);
      chk(dev_addr == 7'h2D, "R4", "two edges after change", dev_addr, 7'h2D);

      cur_req = "R6";
      send_addr(7'h48);
      strap_en_pin = 1'b1; cyc(3);
      chk(dev_addr == 7'h2E, "R6", "non-matching address ignored", dev_addr, 7'h2E);

      cur_req = "R8";
      send_stop(); cyc(1);
      chk(addr_locked == 0, "R8", "stop without match", addr_locked, 0);

      cur_req = "R5";
      strap_en_pin = 1'b0; strap_sel_pin = 1'b1; cyc(3);
      send_addr(7'h2F);
      strap_en_pin = 1'b1; cyc(3);
      chk(dev_addr == 7'h2D, "R5", "captured address held", dev_addr, 7'h2D);

      cur_req = "R9";
      scl_in = 1'b0; cyc(LIMIT - 1);
      chk(bus_reset == 0, "R9", "before limit", bus_reset, 0);
      cyc(1);
      chk(bus_reset == 1, "R9", "at limit", bus_reset, 1);
      cyc(1);
      chk(bus_reset == 0, "R9", "pulse ends", bus_reset, 0);
      cur_req = "R10";
      chk(dev_addr == 7'h2E, "R10", "pending match dropped", dev_addr, 7'h2E);
      cyc(LIMIT);
      chk(bus_reset == 0, "R9", "no repeat while held low", bus_reset, 0);
      scl_in = 1'b1; cyc(2);

      cur_req = "R9";
      sda_in = 1'b0; cyc(LIMIT - 5); sda_in = 1'b1; cyc(1);
      sda_in = 1'b0; cyc(LIMIT - 5);
      chk(bus_reset == 0, "R9", "count cleared by idle", bus_reset, 0);
      tick = 1'b0; cyc(LIMIT);
      chk(bus_reset == 0, "R9", "no count without tick", bus_reset, 0);
      tick = 1'b1; sda_in = 1'b1; cyc(2);

      cur_req = "R10";
      send_addr(7'h2C);
      sda_in = 1'b0; cyc(LIMIT);
      stop_evt = 1'b1; cyc(1); stop_evt = 1'b0; sda_in = 1'b1; cyc(1);
      chk(addr_locked == 0, "R10", "timeout beats stop", addr_locked, 0);

      cur_req = "R7";
      send_addr(7'h2E);
      send_stop();
      chk(addr_locked == 1 && pwm_drv_en == 1 && tach_fan_sel == 1, "R7", "locked modes",
          {addr_locked, pwm_drv_en, tach_fan_sel}, 7);
      chk(dev_addr == 7'h2E, "R7", "locked address", dev_addr, 7'h2E);

      cur_req = "R11";
      strap_en_pin = 1'b0; strap_sel_pin = 1'b0; cyc(3);
      send_addr(7'h2C); send_stop();
      scl_in = 1'b0; cyc(LIMIT + 3); scl_in = 1'b1; cyc(2);
      chk(dev_addr == 7'h2E && addr_locked == 1, "R11", "lock survives traffic",
          {addr_locked, dev_addr}, {1'b1, 7'h2E});

      cur_req = "R1";
      do_reset(); cyc(2);
      chk(addr_locked == 0 && dev_addr == 7'h2C, "R1", "por clears lock",
          {addr_locked, dev_addr}, {1'b0, 7'h2C});
      cur_req = "R7";
      send_addr(7'h2D); send_stop();
      chk(addr_locked == 1 && dev_addr == 7'h2C, "R7", "lock select-low address",
          {addr_locked, dev_addr}, {1'b1, 7'h2C});
      cyc(3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule